// File: doc/BRIEF.md
# Serial DAC Write Controller

This block sits on the host side of a serial-input voltage DAC and runs the three-wire write interface for it: a frame strobe, a serial clock and a serial data line. It also drives the two control lines that the converter needs, an active-low load strobe and an active-low clear strobe. A parent module asks for a write by raising `wr_req` for one cycle with a 16-bit code on `wr_data`. A mode bit `wr_async` chooses how the output is updated. The controller then frames the transfer, shifts the code out most significant bit first, closes the frame and sequences the update. It raises `done` for one cycle when the frame and the update are both complete.

All interface timing comes from the system clock. Each minimum time, in nanoseconds, is converted to whole clock cycles and rounded up, using the `CLK_MHZ` parameter. In synchronous mode the load line is held low from the start of the frame, so the converter updates on the frame strobe's rising edge. In asynchronous mode the load line stays high during the frame and is pulsed low once the frame strobe has risen, so the update happens on that falling edge. A clear request produces a low pulse on the clear line. If the request arrives while a frame is open, the pulse waits until the frame strobe is high again.

Top module: `dacw_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `sync_n`, `sclk`, `ldac_n` and `clr_n` are high and `busy` and `done` are low.
- R2: A frame shifts exactly 16 bits, one per falling edge of `sclk` while `sync_n` is low. Bit 15 of the word goes out first and bit 0 last. Within a frame `sdin` changes only on a rising edge of `sclk`, and it is stable at least 35 ns before every falling edge.
- R3: The `sclk` high and low phases each last at least 35 ns, and consecutive falling edges are at least 100 ns apart. `sclk` is high whenever `sync_n` is high.
- R4: `sync_n` falls at least 10 ns before the first `sclk` falling edge of a frame, and bit 15 is on `sdin` at least 35 ns before that edge.
- R5: `sync_n` rises no earlier than 45 ns after the 16th falling edge of `sclk`, and it stays high for at least 45 ns before the next frame starts.
- R6: In synchronous mode (`wr_async` = 0), `ldac_n` is low throughout the frame and is still low when `sync_n` rises. The update therefore takes place at that rising edge, with the word just shifted.
- R7: In asynchronous mode (`wr_async` = 1), `ldac_n` is high throughout the frame. It falls no earlier than the cycle in which `sync_n` rises and stays low for at least 50 ns. That falling edge is the update, with the word just shifted.
- R8: `busy` is high from the cycle after a request is accepted until the cycle in which `done` is high. `done` is high for exactly one cycle, and never together with `busy`. A `wr_req` that arrives while `busy` is high starts no frame and changes neither the word nor the mode of the frame in progress.
- R9: A `clr_req` pulse that arrives while no frame is open produces exactly one low pulse on `clr_n`, at least 20 ns long.
- R10: A `clr_req` that arrives while `sync_n` is low is held. Its `clr_n` pulse starts only once `sync_n` is high again. No `clr_n` pulse ever starts while `sync_n` is low.
- R11: Each phase of `sclk` lasts max(ceil(35·f), ceil(ceil(100·f)/2)) clock cycles, and a clear pulse lasts ceil(20·f) cycles, where f = `CLK_MHZ`/1000 cycles per ns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_req | input | 1 | One-cycle write request |
| wr_data | input | WORD_W | Code to send, bit 15 first |
| wr_async | input | 1 | Update mode: 1 = load pulse after frame, 0 = update on frame end |
| clr_req | input | 1 | One-cycle clear request |
| sclk | output | 1 | Serial clock, idles high |
| sync_n | output | 1 | Frame strobe, low during a frame |
| sdin | output | 1 | Serial data |
| ldac_n | output | 1 | Load strobe, active low |
| clr_n | output | 1 | Clear strobe, active low |
| busy | output | 1 | Write in progress |
| done | output | 1 | One-cycle completion flag |

## Verification
The bench builds the controller with `CLK_MHZ` = 125, which gives an 8 ns clock. At that rate none of the minimum times is a whole number of cycles: 35 ns, 45 ns, 50 ns and 20 ns become 5, 6, 7 and 3 cycles. A count that rounds down, or that is one cycle short, therefore breaks a nanosecond limit that the bench measures on the pins. The equal 7-cycle length of the asynchronous load pulse and of the SYNC-high window also places the load strobe's rising edge and `done` in the same cycle. That makes the ordering between these two events observable.

// File: rtl/dacw_pkg.sv
package dacw_pkg;

    // Interface minimum times in nanoseconds
    localparam int T_CLK_PHASE_NS = 35;
    localparam int T_CLK_PER_NS   = 100;
    localparam int T_SYNC_SU_NS   = 10;
    localparam int T_DATA_SU_NS   = 35;
    localparam int T_TAIL_NS      = 45;
    localparam int T_SYNC_HI_NS   = 45;
    localparam int T_LOAD_PW_NS   = 50;
    localparam int T_CLR_PW_NS    = 20;

    // Nanoseconds to whole clock cycles, rounded up, never below one
    function automatic int ns2cyc(input int ns, input int mhz);
        int c;
        c = (ns * mhz + 999) / 1000;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LEAD,
        PH_LOW,
        PH_HIGH,
        PH_TAIL,
        PH_GAP
    } phase_e;

endpackage

// File: rtl/dacw_tick_timer.sv
module dacw_tick_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic         expired
);
    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/dacw_shift_out.sv
module dacw_shift_out #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    output logic         msb
);
    logic [W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst)
            sh_q <= '0;
        else if (load)
            sh_q <= load_val;
        else if (shift)
            sh_q <= {sh_q[W-2:0], 1'b0};
    end

    assign msb = sh_q[W-1];
endmodule

// File: rtl/dacw_clr_pulse.sv
module dacw_clr_pulse #(
    parameter int PULSE_C = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic allow,
    output logic clr_n
);
    localparam int CW = $clog2(PULSE_C + 1);

    logic          pend_q;
    logic          act_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            act_q  <= 1'b0;
            cnt_q  <= '0;
            clr_n  <= 1'b1;
        end else if (act_q) begin
            pend_q <= pend_q | req;
            if (cnt_q == '0) begin
                act_q <= 1'b0;
                clr_n <= 1'b1;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end else if ((pend_q | req) && allow) begin
            pend_q <= 1'b0;
            act_q  <= 1'b1;
            clr_n  <= 1'b0;
            cnt_q  <= CW'(PULSE_C - 1);
        end else begin
            pend_q <= pend_q | req;
        end
    end
endmodule

// File: rtl/dacw_ctrl.sv
module dacw_ctrl
    import dacw_pkg::*;
#(
    parameter int CLK_MHZ = 100,
    parameter int WORD_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_req,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              wr_async,
    input  logic              clr_req,
    output logic              sclk,
    output logic              sync_n,
    output logic              sdin,
    output logic              ldac_n,
    output logic              clr_n,
    output logic              busy,
    output logic              done
);
    // Phase lengths in cycles
    localparam int LEAD_MIN = max2(ns2cyc(T_SYNC_SU_NS, CLK_MHZ), ns2cyc(T_DATA_SU_NS, CLK_MHZ));
    localparam int PHASE_C  = max2(max2(ns2cyc(T_CLK_PHASE_NS, CLK_MHZ),
                                        (ns2cyc(T_CLK_PER_NS, CLK_MHZ) + 1) / 2), LEAD_MIN);
    localparam int TAIL_C   = ns2cyc(T_TAIL_NS, CLK_MHZ);
    localparam int SHI_C    = ns2cyc(T_SYNC_HI_NS, CLK_MHZ);
    localparam int LPW_C    = ns2cyc(T_LOAD_PW_NS, CLK_MHZ);
    localparam int GAP_C    = max2(SHI_C, LPW_C);
    localparam int CLR_C    = ns2cyc(T_CLR_PW_NS, CLK_MHZ);
    localparam int MAX_C    = max2(max2(PHASE_C, TAIL_C), max2(GAP_C, CLR_C));
    localparam int CNT_W    = $clog2(MAX_C + 1);
    localparam int BIT_W    = $clog2(WORD_W);

    typedef struct packed {
        phase_e           ph;
        logic [BIT_W-1:0] bit_idx;
        logic             sclk;
        logic             sync_n;
        logic             ldac_n;
        logic             is_async;
        logic             done;
    } ctl_t;

    localparam ctl_t CTL_RST = '{ph: PH_IDLE, bit_idx: '0, sclk: 1'b1, sync_n: 1'b1,
                                 ldac_n: 1'b1, is_async: 1'b0, done: 1'b0};

    ctl_t             cur, nxt;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic [CNT_W-1:0] tmr_cnt;
    logic             tmr_exp;
    logic             sh_load;
    logic             sh_shift;
    logic             start;

    assign start = (cur.ph == PH_IDLE) && wr_req;

    always_comb begin
        nxt      = cur;
        nxt.done = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        unique case (cur.ph)
            PH_IDLE: if (wr_req) begin
                nxt.ph       = PH_LEAD;
                nxt.sync_n   = 1'b0;
                nxt.ldac_n   = wr_async;
                nxt.is_async = wr_async;
                nxt.bit_idx  = '0;
                tmr_load     = 1'b1;
                tmr_val      = CNT_W'(PHASE_C - 1);
                sh_load      = 1'b1;
            end
            PH_LEAD, PH_HIGH: if (tmr_exp) begin
                nxt.ph   = PH_LOW;
                nxt.sclk = 1'b0;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(PHASE_C - 1);
            end
            PH_LOW: if (tmr_exp) begin
                nxt.sclk = 1'b1;
                tmr_load = 1'b1;
                if (cur.bit_idx == BIT_W'(WORD_W - 1)) begin
                    nxt.ph  = PH_TAIL;
                    tmr_val = CNT_W'(TAIL_C - 1);
                end else begin
                    nxt.ph      = PH_HIGH;
                    nxt.bit_idx = cur.bit_idx + 1'b1;
                    sh_shift    = 1'b1;
                    tmr_val     = CNT_W'(PHASE_C - 1);
                end
            end
            PH_TAIL: if (tmr_exp) begin
                nxt.ph     = PH_GAP;
                nxt.sync_n = 1'b1;
                nxt.ldac_n = 1'b0;
                tmr_load   = 1'b1;
                tmr_val    = CNT_W'(GAP_C - 1);
            end
            PH_GAP: begin
                if (tmr_exp) begin
                    nxt.ph     = PH_IDLE;
                    nxt.ldac_n = 1'b1;
                    nxt.done   = 1'b1;
                end else if (cur.is_async && tmr_cnt == CNT_W'(GAP_C - LPW_C)) begin
                    nxt.ldac_n = 1'b1;
                end
            end
            default: nxt = CTL_RST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= CTL_RST;
        else     cur <= nxt;
    end

    dacw_tick_timer #(.W(CNT_W)) i_timer (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val),
        .cnt(tmr_cnt), .expired(tmr_exp)
    );

    dacw_shift_out #(.W(WORD_W)) i_shift (
        .clk(clk), .rst(rst), .load(sh_load), .load_val(wr_data),
        .shift(sh_shift), .msb(sdin)
    );

    dacw_clr_pulse #(.PULSE_C(CLR_C)) i_clr (
        .clk(clk), .rst(rst), .req(clr_req), .allow(cur.sync_n && !start),
        .clr_n(clr_n)
    );

    assign sclk   = cur.sclk;
    assign sync_n = cur.sync_n;
    assign ldac_n = cur.ldac_n;
    assign busy   = (cur.ph != PH_IDLE);
    assign done   = cur.done;
endmodule

// File: rtl/dacw_ctrl_chk.sv
module dacw_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic sclk,
    input logic sync_n,
    input logic sdin,
    input logic ldac_n,
    input logic clr_n,
    input logic busy,
    input logic done
);
    AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst) sync_n |-> sclk); // R3

    AST_SDIN_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        (!sync_n && $past(!sync_n) && (sdin != $past(sdin))) |-> $rose(sclk)); // R2

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R8

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst) done |-> !busy); // R8

    AST_CLR_START_HIGH: assert property (@(posedge clk) disable iff (rst)
        $fell(clr_n) |-> sync_n); // R10

    AST_LOAD_FALL_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        $fell(ldac_n) |-> ($fell(sync_n) || $rose(sync_n))); // R7
endmodule

bind dacw_ctrl dacw_ctrl_chk i_dacw_chk (
    .clk(clk), .rst(rst), .sclk(sclk), .sync_n(sync_n), .sdin(sdin),
    .ldac_n(ldac_n), .clr_n(clr_n), .busy(busy), .done(done)
);

// File: tb/test_dacw_ctrl.sv
module test_dacw_ctrl;
    localparam int CLK_PERIOD_NS = 8;
    localparam int CLK_MHZ       = 1000 / CLK_PERIOD_NS;
    localparam int EXP_PHASE     = ((35 * CLK_MHZ + 999) / 1000 > ((100 * CLK_MHZ + 999) / 1000 + 1) / 2)
                                   ? (35 * CLK_MHZ + 999) / 1000 : ((100 * CLK_MHZ + 999) / 1000 + 1) / 2;
    localparam int EXP_CLR       = (20 * CLK_MHZ + 999) / 1000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_req = 1'b0;
    logic [15:0] wr_data = '0;
    logic        wr_async = 1'b0;
    logic        clr_req = 1'b0;
    logic        sclk, sync_n, sdin, ldac_n, clr_n, busy, done;

    dacw_ctrl #(.CLK_MHZ(CLK_MHZ), .WORD_W(16)) i_dacw_ctrl (
        .clk(clk), .rst(rst), .wr_req(wr_req), .wr_data(wr_data), .wr_async(wr_async),
        .clr_req(clr_req), .sclk(sclk), .sync_n(sync_n), .sdin(sdin), .ldac_n(ldac_n),
        .clr_n(clr_n), .busy(busy), .done(done)
    );

    always #(CLK_PERIOD_NS / 2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Pin monitor: a converter model plus nanosecond limit checks
    int          cyc = 0;
    logic        p_sclk, p_sync, p_ldac, p_clr, p_sdin;
    int          t_rise, t_fall, t_sfall, t_srise, t_sdin, t_lfall, t_cfall;
    int          bits;
    logic [15:0] cap, frame_word, upd_word;
    int          upd_cnt = 0;
    bit          upd_async;
    int          clr_cnt = 0;
    int          last_lo_w, last_clr_w;
    bit          load_low;
    bit          exp_async = 1'b0;

    always @(negedge clk) begin
        if (rst) begin
            p_sclk = sclk; p_sync = sync_n; p_ldac = ldac_n; p_clr = clr_n; p_sdin = sdin;
            cyc = 0; t_rise = -1000; t_fall = -1000; t_sfall = -1000; t_srise = -1000;
            t_sdin = -1000; t_lfall = 0; t_cfall = 0; bits = 0; load_low = 0;
        end else begin
            cyc++;
            if (sdin !== p_sdin) t_sdin = cyc;
            if (p_sync && !sync_n) begin
                check((cyc - t_srise) * CLK_PERIOD_NS >= 45, "R5 sync high gap ns",
                      (cyc - t_srise) * CLK_PERIOD_NS, 45);
                t_sfall = cyc;
                bits = 0;
            end
            if (!p_sclk && sclk) begin
                last_lo_w = cyc - t_fall;
                check(last_lo_w * CLK_PERIOD_NS >= 35, "R3 sclk low ns", last_lo_w * CLK_PERIOD_NS, 35);
                t_rise = cyc;
            end
            if (p_sclk && !sclk) begin
                check(!sync_n, "R3 sclk falls only in frame", int'(sync_n), 0);
                check((cyc - t_rise) * CLK_PERIOD_NS >= 35, "R3 sclk high ns",
                      (cyc - t_rise) * CLK_PERIOD_NS, 35);
                check(ldac_n == exp_async, exp_async ? "R7 load high in frame" : "R6 load low in frame",
                      int'(ldac_n), int'(exp_async));
                if (bits == 0) begin
                    check((cyc - t_sfall) * CLK_PERIOD_NS >= 10, "R4 sync setup ns",
                          (cyc - t_sfall) * CLK_PERIOD_NS, 10);
                    check((cyc - t_sdin) * CLK_PERIOD_NS >= 35, "R4 first bit setup ns",
                          (cyc - t_sdin) * CLK_PERIOD_NS, 35);
                end else begin
                    check((cyc - t_fall) * CLK_PERIOD_NS >= 100, "R3 sclk period ns",
                          (cyc - t_fall) * CLK_PERIOD_NS, 100);
                    check((cyc - t_sdin) * CLK_PERIOD_NS >= 35, "R2 data setup ns",
                          (cyc - t_sdin) * CLK_PERIOD_NS, 35);
                end
                cap = {cap[14:0], sdin};
                bits++;
                t_fall = cyc;
            end
            if (!p_sync && sync_n) begin
                check(bits == 16, "R2 bits per frame", bits, 16);
                check((cyc - t_fall) * CLK_PERIOD_NS >= 45, "R5 tail ns",
                      (cyc - t_fall) * CLK_PERIOD_NS, 45);
                t_srise = cyc;
                frame_word = cap;
                if (!p_ldac) begin
                    upd_cnt++; upd_word = cap; upd_async = 1'b0;
                end
            end
            if (p_ldac && !ldac_n && sync_n) begin
                upd_cnt++; upd_word = frame_word; upd_async = 1'b1;
                t_lfall = cyc; load_low = 1'b1;
            end
            if (!p_ldac && ldac_n && load_low) begin
                check((cyc - t_lfall) * CLK_PERIOD_NS >= 50, "R7 load pulse ns",
                      (cyc - t_lfall) * CLK_PERIOD_NS, 50);
                load_low = 1'b0;
            end
            if (p_clr && !clr_n) begin
                check(sync_n == 1'b1, "R10 clear starts with sync high", int'(sync_n), 1);
                t_cfall = cyc;
            end
            if (!p_clr && clr_n) begin
                last_clr_w = cyc - t_cfall;
                check(last_clr_w * CLK_PERIOD_NS >= 20, "R9 clear pulse ns", last_clr_w * CLK_PERIOD_NS, 20);
                clr_cnt++;
            end
            p_sclk = sclk; p_sync = sync_n; p_ldac = ldac_n; p_clr = clr_n; p_sdin = sdin;
        end
    end

    task automatic wait_done(output bit seen);
        int w = 0;
        while (!done && w < 3000) begin
            @(negedge clk);
            w++;
        end
        seen = done;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check({sync_n, sclk, ldac_n, clr_n, busy, done} == 6'b111100, "R1 outputs in reset",
              int'({sync_n, sclk, ldac_n, clr_n, busy, done}), 6'b111100);
        rst = 1'b0;
        @(negedge clk);
        check({sync_n, sclk, ldac_n, clr_n, busy, done} == 6'b111100, "R1 outputs after reset",
              int'({sync_n, sclk, ldac_n, clr_n, busy, done}), 6'b111100);
    endtask

    task automatic do_write(input logic [15:0] d, input bit as);
        int  u0 = upd_cnt;
        bit  seen;
        string tg = as ? "R7" : "R6";
        while (busy) @(negedge clk);
        exp_async = as;
        wr_data = d; wr_async = as; wr_req = 1'b1;
        @(negedge clk);
        wr_req = 1'b0;
        check(busy == 1'b1, "R8 busy after accept", int'(busy), 1);
        wait_done(seen);
        check(seen, "R8 done reached", int'(seen), 1);
        check(upd_cnt == u0 + 1, {tg, " one update"}, upd_cnt - u0, 1);
        check(upd_word == d, {tg, " updated word"}, int'(upd_word), int'(d));
        check(upd_async == as, {tg, " update edge kind"}, int'(upd_async), int'(as));
        check(last_lo_w == EXP_PHASE, "R11 sclk phase cycles", last_lo_w, EXP_PHASE);
        @(negedge clk);
        check(done == 1'b0, "R8 done one cycle", int'(done), 0);
    endtask

    task automatic t_ignore_busy();
        int u0 = upd_cnt;
        bit seen;
        exp_async = 1'b0;
        wr_data = 16'hA55A; wr_async = 1'b0; wr_req = 1'b1;
        @(negedge clk);
        wr_req = 1'b0;
        repeat (20) @(negedge clk);
        wr_data = 16'h1234; wr_async = 1'b1; wr_req = 1'b1;
        @(negedge clk);
        wr_req = 1'b0;
        wait_done(seen);
        check(upd_word == 16'hA55A, "R8 word kept while busy", int'(upd_word), 16'hA55A);
        check(upd_async == 1'b0, "R8 mode kept while busy", int'(upd_async), 0);
        repeat (60) @(negedge clk);
        check(upd_cnt == u0 + 1, "R8 ignored request starts no frame", upd_cnt - u0, 1);
        check(busy == 1'b0, "R8 idle after ignored request", int'(busy), 0);
    endtask

    task automatic t_clear_idle();
        int c0 = clr_cnt;
        clr_req = 1'b1;
        @(negedge clk);
        clr_req = 1'b0;
        repeat (12) @(negedge clk);
        check(clr_cnt == c0 + 1, "R9 one clear pulse", clr_cnt - c0, 1);
        check(last_clr_w == EXP_CLR, "R11 clear pulse cycles", last_clr_w, EXP_CLR);
    endtask

    task automatic t_clear_in_frame();
        int c0 = clr_cnt;
        int u0 = upd_cnt;
        bit early = 1'b0;
        bit seen;
        exp_async = 1'b1;
        wr_data = 16'h0F0F; wr_async = 1'b1; wr_req = 1'b1;
        @(negedge clk);
        wr_req = 1'b0;
        repeat (30) @(negedge clk);
        clr_req = 1'b1;
        @(negedge clk);
        clr_req = 1'b0;
        while (!sync_n) begin
            if (!clr_n) early = 1'b1;
            @(negedge clk);
        end
        check(!early, "R10 clear held during frame", int'(early), 0);
        wait_done(seen);
        repeat (10) @(negedge clk);
        check(clr_cnt == c0 + 1, "R10 queued clear issued", clr_cnt - c0, 1);
        check(upd_cnt == u0 + 1 && upd_word == 16'h0F0F, "R7 update intact with clear",
              int'(upd_word), 16'h0F0F);
    endtask

    initial begin
        #(CLK_PERIOD_NS * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL R8 watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        do_write(16'hB3C1, 1'b0);
        do_write(16'h8001, 1'b1);
        do_write(16'hFFFF, 1'b0);
        do_write(16'h0000, 1'b1);
        do_write(16'h5AA5, 1'b0);
        t_ignore_busy();
        t_clear_idle();
        t_clear_in_frame();
        do_write(16'h7FFE, 1'b1);
        repeat (5) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule